// File: doc/BRIEF.md
# Converter Mode Selection Controller

This block decides whether a synchronous buck converter runs in fixed-frequency PWM operation or in hysteretic light-load operation. On each switching cycle a strobe marks the end of the low-side conduction interval, just before the high-side switch would turn on. On that strobe the block reads a phase-polarity comparator bit. A low bit means the switch node was negative and the inductor current is continuous. A high bit means the node was positive and the inductor current is reversing.

A mode change needs a run of consecutive samples that point the same way. In PWM, a run of high samples moves the converter into hysteretic mode. In hysteretic mode, a run of low samples moves it back. Requiring a run stops the mode from chattering near the load boundary. A separate droop comparator bit reports that the output has fallen below the hysteretic regulation level. While the block is in hysteretic mode, that bit returns it to PWM on the next clock so that full power is available at once. On entry into hysteretic mode the block emits a one-clock request to turn both power switches off. Some block further down the path arbitrates that request against the gate drive.

Top module: `mode_selector`

## Requirements
- R1: After reset `modeHyst` is 0 (PWM) and `bothOffPulse` is 0.
- R2: In PWM mode, if `phasePos` is 1 on RUN_LEN consecutive strobes (RUN_LEN defaults to 8), `modeHyst` becomes 1 in the cycle that follows the clock edge of the last of those strobes.
- R3: In hysteretic mode, if `phasePos` is 0 on RUN_LEN consecutive strobes, `modeHyst` becomes 0 in the cycle that follows the clock edge of the last of those strobes.
- R4: `phasePos` is read only on clock edges where `sampleStb` is 1. Its value on other edges has no effect on the mode or on the run.
- R5: One strobe that disagrees with the current run clears the run. After it, RUN_LEN new agreeing strobes are needed.
- R6: `bothOffPulse` is 1 for exactly one cycle, the first cycle of hysteretic mode. It is never raised on a return to PWM.
- R7: In hysteretic mode, `outBelowHyst` = 1 on a clock edge makes `modeHyst` 0 in the next cycle, whatever the strobe and phase inputs are. This exit does not raise `bothOffPulse`, and it takes priority over a strobe on the same edge.
- R8: In PWM mode, `outBelowHyst` has no effect.
- R9: Every mode change, whether after a run or after a droop, clears the run. The next decision needs RUN_LEN new samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStb | input | 1 | End of low-side conduction; qualifies phasePos |
| phasePos | input | 1 | Phase comparator: 1 = node positive, 0 = negative |
| outBelowHyst | input | 1 | Output below hysteretic regulation level |
| modeHyst | output | 1 | 1 = hysteretic mode, 0 = PWM mode |
| bothOffPulse | output | 1 | One-clock request to turn both switches off |

## Verification
Directed runs apply 7 and then 8 agreeing strobes in each mode. Comparing the two shows that the transition happens on exactly the eighth sample and in the cycle predicted for it. A run is broken once by a disagreeing strobe and once by idle cycles that carry the opposite phase. The first case shows that the count is cleared. The second shows that it is held. Droop is asserted in PWM, and in hysteretic mode both alone and together with a strobe. This separates the forced exit from the counted one and checks the priority between them. A long pseudo-random sequence follows, with the phase biased toward long runs. An arithmetic run-length model predicts the mode and the off pulse on every step of it.

// File: rtl/modesel_pkg.sv
package modesel_pkg;
  // Strobes from the mode decider to the run counter
  typedef struct packed {
    logic clear;    // drop the current run to zero
    logic advance;  // one more agreeing sample
  } runCtl_t;
endpackage

// File: rtl/mode_run_counter.sv
module mode_run_counter
  import modesel_pkg::*;
#(
  parameter int RUN_LEN = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  runCtl_t ctl,
  output logic    runFull
);
  localparam int CW = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN)             runCnt <= '0;
    else if (ctl.clear)    runCnt <= '0;
    else if (ctl.advance && runCnt != LAST) runCnt <= runCnt + 1'b1;
  end

  // High once RUN_LEN-1 samples agree; the next agreeing sample completes the run
  assign runFull = (runCnt == LAST);

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= LAST); // R5
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (runCnt == '0)); // R9
  AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !ctl.clear && !runFull) |=> (runCnt == $past(runCnt) + 1'b1)); // R2
endmodule

// File: rtl/mode_decider.sv
module mode_decider
  import modesel_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sampleStb,
  input  logic    phasePos,
  input  logic    outBelowHyst,
  input  logic    runFull,
  output runCtl_t ctl,
  output logic    modeHyst,
  output logic    bothOffPulse
);
  logic agree, hit, droopExit, swap;

  always_comb begin
    // A sample agrees when it argues for leaving the current mode
    agree       = modeHyst ? !phasePos : phasePos;
    hit         = sampleStb && agree;
    droopExit   = modeHyst && outBelowHyst;
    swap        = hit && runFull && !droopExit;
    ctl.clear   = droopExit || swap || (sampleStb && !agree);
    ctl.advance = hit && !runFull && !droopExit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeHyst     <= 1'b0;
      bothOffPulse <= 1'b0;
    end else begin
      bothOffPulse <= swap && !modeHyst;
      if (droopExit)  modeHyst <= 1'b0;
      else if (swap)  modeHyst <= !modeHyst;
    end
  end

  AST_DROOP_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (modeHyst && outBelowHyst) |=> !modeHyst); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleStb && !(modeHyst && outBelowHyst)) |=> $stable(modeHyst)); // R4
  AST_OFF_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    bothOffPulse |=> !bothOffPulse); // R6
  AST_OFF_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    bothOffPulse |-> modeHyst); // R6
  AST_PWM_DROOP_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!modeHyst && !sampleStb) |=> !modeHyst); // R8
endmodule

// File: rtl/mode_selector.sv
module mode_selector
  import modesel_pkg::*;
#(
  parameter int RUN_LEN = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic sampleStb,
  input  logic phasePos,
  input  logic outBelowHyst,
  output logic modeHyst,
  output logic bothOffPulse
);
  runCtl_t runCtl;
  logic    runFull;

  mode_decider decider_i (
    .clk          (clk),
    .rstN         (rstN),
    .sampleStb    (sampleStb),
    .phasePos     (phasePos),
    .outBelowHyst (outBelowHyst),
    .runFull      (runFull),
    .ctl          (runCtl),
    .modeHyst     (modeHyst),
    .bothOffPulse (bothOffPulse)
  );

  mode_run_counter #(.RUN_LEN(RUN_LEN)) counter_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (runCtl),
    .runFull (runFull)
  );
endmodule

// File: tb/mode_selector_tb_top.sv
module mode_selector_tb_top;
  localparam int RUN_LEN = 8;

  logic clk = 1'b0;
  logic rstN, sampleStb, phasePos, outBelowHyst;
  logic modeHyst, bothOffPulse;

  int nVec = 0;
  int nBad = 0;
  int cycles = 0;

  // Reference state, updated from the requirements
  bit expHyst = 0;
  bit expOff = 0;
  int expRun = 0;

  always #5 clk = ~clk;

  mode_selector #(.RUN_LEN(RUN_LEN)) dut_i (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .phasePos(phasePos),
    .outBelowHyst(outBelowHyst), .modeHyst(modeHyst), .bothOffPulse(bothOffPulse)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nBad++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  task automatic check(input string tag);
    nVec++;
    if (modeHyst !== expHyst || bothOffPulse !== expOff) begin
      nBad++;
      $display("FAIL %s: actual mode=%b off=%b, expected mode=%b off=%b",
               tag, modeHyst, bothOffPulse, expHyst, expOff);
    end
  endtask

  // One clock: drive at the falling edge, let the rising edge act, check at the next falling edge
  task automatic step(input bit stb, input bit ph, input bit low, input string tag);
    bit q;
    sampleStb = stb; phasePos = ph; outBelowHyst = low;
    expOff = 0;
    if (expHyst && low) begin
      expHyst = 0; expRun = 0;                       // R7, R9
    end else if (stb) begin
      q = expHyst ? !ph : ph;
      if (!q) expRun = 0;                            // R5
      else if (expRun == RUN_LEN - 1) begin
        if (!expHyst) expOff = 1;                    // R6
        expHyst = !expHyst; expRun = 0;              // R2, R3, R9
      end else expRun++;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic runOf(input int n, input bit ph, input string tag);
    for (int i = 0; i < n; i++) step(1, ph, 0, tag);
  endtask

  initial begin
    bit [15:0] lfsr = 16'hACE1;
    rstN = 0; sampleStb = 0; phasePos = 0; outBelowHyst = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset");
    rstN = 1;

    // R2: seven high samples do not switch, the eighth does
    runOf(7, 1, "R2 short run");
    step(1, 1, 0, "R2 eighth sample");
    step(0, 0, 0, "R6 pulse ends");
    // R3 with idle cycles carrying high phase (R4): run is held, not cleared
    runOf(4, 0, "R3 partial");
    for (int i = 0; i < 3; i++) step(0, 1, 0, "R4 idle phase ignored");
    runOf(3, 0, "R3 partial");
    step(1, 0, 0, "R3 eighth low sample");
    // R5: break a high run at seven
    runOf(7, 1, "R5 run of seven");
    step(1, 0, 0, "R5 disagreeing sample");
    runOf(7, 1, "R5 not yet");
    step(1, 1, 0, "R5 eighth after break");
    // R9: after entry, low run restarts from zero
    runOf(7, 0, "R9 fresh count");
    step(1, 0, 0, "R9 exit");
    // R8: droop ignored in PWM
    for (int i = 0; i < 4; i++) step(i[0], 1, 1, "R8 droop in PWM");
    runOf(8, 1, "R2 reenter");
    // R7: droop with a strobe on the same edge
    runOf(5, 0, "R7 partial low run");
    step(1, 0, 1, "R7 droop exit");
    runOf(7, 1, "R9 count after droop");
    step(1, 1, 0, "R9 entry after droop");
    step(0, 0, 1, "R7 droop alone");

    // Biased pseudo-random sweep
    for (int k = 0; k < 4000; k++) begin
      bit stb, ph, low;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      stb = lfsr[4] | lfsr[5];
      ph  = expHyst ? (lfsr[3:0] < 2) : (lfsr[3:0] >= 2);
      low = (lfsr[11:8] == 4'd0);
      step(stb, ph, low, "R2 R3 R7 sweep");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule